// File: doc/BRIEF.md
# Width-Converting Bus-Matching Port

This block joins a 36-bit storage side to an 18-bit external bus. The transmit path takes each 36-bit entry and sends it out as a sequence of narrow pieces. The receive path does the reverse: it collects narrow pieces and assembles them into 36-bit entries. The wide side of each path has a small synchronous FIFO, so the block can be used and tested on its own. Every boundary uses a valid/ready handshake.

Two static inputs set how the block behaves. The size input selects word sizing (two 18-bit pieces) or byte sizing (four 9-bit pieces carried on bus bits 8:0). The endian input selects which end of the entry travels first. Both inputs are captured while reset is asserted and stay fixed until the next reset. The same setting applies to both directions.

Top module: `bus_match_port`

## Requirements
- R1: While reset is asserted and directly after it is released, both narrow and wide outputs show no valid data, and both input-side ready outputs are high.
- R2: In word mode (byte_mode_i=0), each transmit entry leaves as two 18-bit pieces. With big_endian_i=1 bits 35:18 go first and then bits 17:0. With big_endian_i=0 the order is reversed.
- R3: In byte mode (byte_mode_i=1), each transmit entry leaves as four 9-bit pieces on bits 8:0, and bits 17:9 are zero. With big_endian_i=1 the order is bits 35:27, 26:18, 17:9, 8:0. With big_endian_i=0 the order is reversed.
- R4: In word mode, two received 18-bit pieces form one wide entry. The first piece fills bits 35:18 when big-endian and bits 17:0 when little-endian.
- R5: In byte mode, four received pieces form one wide entry from bits 8:0 of each piece, and bits 17:9 are ignored. The first piece fills bits 35:27 when big-endian and bits 8:0 when little-endian.
- R6: While the narrow transmit output is valid and not accepted, its data stays constant. No piece is lost or sent twice.
- R7: A received entry becomes visible on the wide output only after its last piece is accepted. Back-pressure stalls the piece position without losing or duplicating pieces.
- R8: Changes to byte_mode_i or big_endian_i after reset release have no effect until the next reset.
- R9: Each wide-side FIFO holds DEPTH entries (default 4) in order. Its ready output goes low when it is full, and the transmit FIFO entry is freed only after its last piece is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; configuration is captured while it is low |
| byte_mode_i | input | 1 | 1 = byte sizing, 0 = word sizing |
| big_endian_i | input | 1 | 1 = most significant piece first |
| tx_wdata_i | input | 36 | Wide entry written into the transmit FIFO |
| tx_wvalid_i | input | 1 | Transmit write valid |
| tx_wready_o | output | 1 | Transmit FIFO has room |
| tx_ndata_o | output | 18 | Narrow transmit piece |
| tx_nvalid_o | output | 1 | Narrow transmit piece valid |
| tx_nready_i | input | 1 | Narrow transmit piece accepted |
| rx_ndata_i | input | 18 | Narrow received piece |
| rx_nvalid_i | input | 1 | Narrow received piece valid |
| rx_nready_o | output | 1 | Received piece can be accepted |
| rx_wdata_o | output | 36 | Assembled wide entry at the receive FIFO head |
| rx_wvalid_o | output | 1 | Receive FIFO not empty |
| rx_wready_i | input | 1 | Pop the receive FIFO head |

## Verification
The assertions assume that the environment follows the valid/ready handshake. They also assume that size and endian are held stable for the whole time reset is low, because the captured value is whatever those inputs show at release. The bench drives every input only at falling edges. It raises a valid and holds it until ready has been seen at a rising edge, and it changes configuration inputs only during reset or as a deliberate check of R8. All four size and endian combinations are swept with distinct piece values, and stalls and full FIFOs are inserted at fixed points.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int unsigned WIDE_W   = 36;
  localparam int unsigned NARROW_W = 18;
  localparam int unsigned FIFO_D   = 4;

  typedef struct packed {
    logic byte_mode;
    logic big_end;
  } bm_cfg_t;
endpackage

// File: rtl/bm_fifo.sv
module bm_fifo #(
  parameter int unsigned W     = 36,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         ready_o,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  input  logic         pop_i
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  assign ready_o = cnt_q != CW'(DEPTH);
  assign valid_o = cnt_q != '0;
  assign data_o  = mem_q[rd_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> ready_o); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> valid_o); // R9
endmodule

// File: rtl/bm_unpack.sv
module bm_unpack
  import bm_pkg::*;
#(
  parameter int unsigned WIDE_W   = bm_pkg::WIDE_W,
  parameter int unsigned NARROW_W = bm_pkg::NARROW_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  bm_cfg_t             cfg_i,
  input  logic [WIDE_W-1:0]   w_data_i,
  input  logic                w_valid_i,
  output logic                w_pop_o,
  output logic [NARROW_W-1:0] n_data_o,
  output logic                n_valid_o,
  input  logic                n_ready_i
);
  localparam int unsigned BYTE_W = NARROW_W / 2;
  localparam int unsigned WORDS  = WIDE_W / NARROW_W;
  localparam int unsigned BYTES  = WIDE_W / BYTE_W;
  localparam int unsigned CNT_W  = $clog2(BYTES);

  logic [CNT_W-1:0] cnt_q, last_idx, idx;
  logic             hs, last;

  assign last_idx  = cfg_i.byte_mode ? CNT_W'(BYTES - 1) : CNT_W'(WORDS - 1);
  assign idx       = cfg_i.big_end ? last_idx - cnt_q : cnt_q;
  assign n_valid_o = w_valid_i;
  assign hs        = n_valid_o & n_ready_i;
  assign last      = cnt_q == last_idx;
  assign w_pop_o   = hs & last;

  always_comb begin
    n_data_o = '0;
    if (cfg_i.byte_mode) n_data_o[BYTE_W-1:0] = w_data_i[int'(idx)*BYTE_W +: BYTE_W];
    else                 n_data_o = w_data_i[int'(idx)*NARROW_W +: NARROW_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (hs)   cnt_q <= last ? '0 : cnt_q + 1'b1;
  end

  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_valid_o && !n_ready_i) |=> (n_valid_o && $stable(n_data_o))); // R6
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_valid_o && cfg_i.byte_mode) |-> (n_data_o[NARROW_W-1:BYTE_W] == '0)); // R3
endmodule

// File: rtl/bm_pack.sv
module bm_pack
  import bm_pkg::*;
#(
  parameter int unsigned WIDE_W   = bm_pkg::WIDE_W,
  parameter int unsigned NARROW_W = bm_pkg::NARROW_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  bm_cfg_t             cfg_i,
  input  logic [NARROW_W-1:0] n_data_i,
  input  logic                n_valid_i,
  output logic                n_ready_o,
  output logic [WIDE_W-1:0]   w_data_o,
  output logic                w_push_o,
  input  logic                w_ready_i
);
  localparam int unsigned BYTE_W = NARROW_W / 2;
  localparam int unsigned WORDS  = WIDE_W / NARROW_W;
  localparam int unsigned BYTES  = WIDE_W / BYTE_W;
  localparam int unsigned CNT_W  = $clog2(BYTES);

  logic [CNT_W-1:0]  cnt_q, last_idx, idx;
  logic [WIDE_W-1:0] acc_q, merged;
  logic              hs, last;

  assign last_idx  = cfg_i.byte_mode ? CNT_W'(BYTES - 1) : CNT_W'(WORDS - 1);
  assign idx       = cfg_i.big_end ? last_idx - cnt_q : cnt_q;
  assign last      = cnt_q == last_idx;
  // only the final piece needs room on the wide side
  assign n_ready_o = !last || w_ready_i;
  assign hs        = n_valid_i & n_ready_o;
  assign w_push_o  = hs & last;
  assign w_data_o  = merged;

  always_comb begin
    merged = acc_q;
    if (cfg_i.byte_mode) merged[int'(idx)*BYTE_W +: BYTE_W] = n_data_i[BYTE_W-1:0];
    else                 merged[int'(idx)*NARROW_W +: NARROW_W] = n_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (hs) begin
      cnt_q <= last ? '0 : cnt_q + 1'b1;
      acc_q <= merged;
    end
  end

  AST_RX_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_valid_i && !n_ready_o) |=> $stable(cnt_q)); // R7
  AST_RX_PUSH_ON_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_push_o |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/bus_match_port.sv
module bus_match_port
  import bm_pkg::*;
#(
  parameter int unsigned WIDE_W   = bm_pkg::WIDE_W,
  parameter int unsigned NARROW_W = bm_pkg::NARROW_W,
  parameter int unsigned DEPTH    = bm_pkg::FIFO_D
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                byte_mode_i,
  input  logic                big_endian_i,
  input  logic [WIDE_W-1:0]   tx_wdata_i,
  input  logic                tx_wvalid_i,
  output logic                tx_wready_o,
  output logic [NARROW_W-1:0] tx_ndata_o,
  output logic                tx_nvalid_o,
  input  logic                tx_nready_i,
  input  logic [NARROW_W-1:0] rx_ndata_i,
  input  logic                rx_nvalid_i,
  output logic                rx_nready_o,
  output logic [WIDE_W-1:0]   rx_wdata_o,
  output logic                rx_wvalid_o,
  input  logic                rx_wready_i
);
  bm_cfg_t cfg_q;

  // configuration follows the pins only while reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '{byte_mode: byte_mode_i, big_end: big_endian_i};
    else         cfg_q <= cfg_q;
  end

  logic [WIDE_W-1:0] txf_data, rxf_data;
  logic              txf_valid, txf_pop, txf_ready;
  logic              rxf_push, rxf_ready;

  assign txf_ready = tx_wready_o;

  bm_fifo #(.W(WIDE_W), .DEPTH(DEPTH)) i_tx_fifo (
    .clk_i, .rst_ni,
    .push_i (tx_wvalid_i & txf_ready), .data_i (tx_wdata_i), .ready_o (tx_wready_o),
    .valid_o(txf_valid), .data_o(txf_data), .pop_i(txf_pop)
  );

  bm_unpack #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) i_unpack (
    .clk_i, .rst_ni, .cfg_i(cfg_q),
    .w_data_i(txf_data), .w_valid_i(txf_valid), .w_pop_o(txf_pop),
    .n_data_o(tx_ndata_o), .n_valid_o(tx_nvalid_o), .n_ready_i(tx_nready_i)
  );

  bm_pack #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) i_pack (
    .clk_i, .rst_ni, .cfg_i(cfg_q),
    .n_data_i(rx_ndata_i), .n_valid_i(rx_nvalid_i), .n_ready_o(rx_nready_o),
    .w_data_o(rxf_data), .w_push_o(rxf_push), .w_ready_i(rxf_ready)
  );

  bm_fifo #(.W(WIDE_W), .DEPTH(DEPTH)) i_rx_fifo (
    .clk_i, .rst_ni,
    .push_i (rxf_push), .data_i (rxf_data), .ready_o (rxf_ready),
    .valid_o(rx_wvalid_o), .data_o(rx_wdata_o), .pop_i(rx_wready_i & rx_wvalid_o)
  );

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(cfg_q)); // R8
endmodule

// File: tb/test_bus_match_port.sv
module test_bus_match_port;
  logic        clk = 0, rst_n = 0;
  logic        byte_mode = 0, big_end = 0;
  logic [35:0] tx_wdata = '0;
  logic        tx_wvalid = 0, tx_wready;
  logic [17:0] tx_ndata;
  logic        tx_nvalid, tx_nready = 0;
  logic [17:0] rx_ndata = '0;
  logic        rx_nvalid = 0, rx_nready;
  logic [35:0] rx_wdata;
  logic        rx_wvalid, rx_wready = 0;

  int checks = 0, errors = 0;
  bit bm_eff = 0, be_eff = 0;

  always #10 clk = ~clk;

  bus_match_port i_bus_match_port (
    .clk_i(clk), .rst_ni(rst_n), .byte_mode_i(byte_mode), .big_endian_i(big_end),
    .tx_wdata_i(tx_wdata), .tx_wvalid_i(tx_wvalid), .tx_wready_o(tx_wready),
    .tx_ndata_o(tx_ndata), .tx_nvalid_o(tx_nvalid), .tx_nready_i(tx_nready),
    .rx_ndata_i(rx_ndata), .rx_nvalid_i(rx_nvalid), .rx_nready_o(rx_nready),
    .rx_wdata_o(rx_wdata), .rx_wvalid_o(rx_wvalid), .rx_wready_i(rx_wready)
  );

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [17:0] exp_piece(input logic [35:0] e, input bit bm, input bit be, input int k);
    int n = bm ? 4 : 2;
    int p = be ? n - 1 - k : k;
    if (bm) return {9'b0, e[p*9 +: 9]};
    return e[p*18 +: 18];
  endfunction

  function automatic logic [35:0] mk(input int i);
    return {9'(i*7 + 11), 9'(i*7 + 12), 9'(i*7 + 13), 9'(i*7 + 14)} ^ 36'h9_1B2_4C6A;
  endfunction

  task automatic do_reset(input bit bm, input bit be);
    rst_n = 0; byte_mode = bm; big_end = be;
    tx_wvalid = 0; tx_nready = 0; rx_nvalid = 0; rx_wready = 0;
    bm_eff = bm; be_eff = be;
    repeat (3) @(negedge clk);
    chk(!tx_nvalid && !rx_wvalid && tx_wready && rx_nready, "R1 in reset",
        {tx_nvalid, rx_wvalid, tx_wready, rx_nready}, 4'b0011);
    rst_n = 1;
    @(negedge clk);
    chk(!tx_nvalid && !rx_wvalid && tx_wready && rx_nready, "R1 after reset",
        {tx_nvalid, rx_wvalid, tx_wready, rx_nready}, 4'b0011);
  endtask

  task automatic send_wide(input logic [35:0] e);
    tx_wdata = e; tx_wvalid = 1;
    while (!tx_wready) @(negedge clk);
    @(negedge clk);
    tx_wvalid = 0;
  endtask

  task automatic recv_narrow(input logic [17:0] exp, input bit stall, input string tag);
    while (!tx_nvalid) @(negedge clk);
    chk(tx_ndata == exp, tag, 36'(tx_ndata), 36'(exp));
    if (stall) begin
      @(negedge clk);
      chk(tx_nvalid && tx_ndata == exp, "R6 stall hold", 36'(tx_ndata), 36'(exp));
    end
    tx_nready = 1;
    @(negedge clk);
    tx_nready = 0;
  endtask

  task automatic tx_entry(input logic [35:0] e, input bit stall, input string tag);
    send_wide(e);
    for (int k = 0; k < (bm_eff ? 4 : 2); k++)
      recv_narrow(exp_piece(e, bm_eff, be_eff, k), stall && k == 0, tag);
  endtask

  task automatic send_narrow(input logic [17:0] d);
    rx_ndata = d; rx_nvalid = 1;
    while (!rx_nready) @(negedge clk);
    @(negedge clk);
    rx_nvalid = 0;
  endtask

  function automatic logic [17:0] rx_piece(input logic [35:0] e, input int k);
    logic [17:0] p = exp_piece(e, bm_eff, be_eff, k);
    if (bm_eff) p[17:9] = 9'h1A5 ^ 9'(k); // junk in the ignored half
    return p;
  endfunction

  task automatic read_wide(input logic [35:0] exp, input string tag);
    while (!rx_wvalid) @(negedge clk);
    chk(rx_wdata == exp, tag, rx_wdata, exp);
    rx_wready = 1;
    @(negedge clk);
    rx_wready = 0;
  endtask

  task automatic rx_entry(input logic [35:0] e, input string tag);
    int n = bm_eff ? 4 : 2;
    for (int k = 0; k < n; k++) begin
      send_narrow(rx_piece(e, k));
      if (k < n - 1) chk(!rx_wvalid, "R7 early entry", 36'(rx_wvalid), 36'd0);
    end
    chk(rx_wvalid, "R7 entry after last", 36'(rx_wvalid), 36'd1);
    read_wide(e, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R2 R3 R4 R5 R6: sweep all size/endian settings
    for (int c = 0; c < 4; c++) begin
      do_reset(c[1], c[0]);
      for (int i = 0; i < 6; i++) begin
        tx_entry(mk(i + c*8), i == 2, c[1] ? "R3 tx byte" : "R2 tx word");
        rx_entry(mk(i + c*8 + 3), c[1] ? "R5 rx byte" : "R4 rx word");
      end
    end

    // R8: pins changed after reset are ignored
    do_reset(0, 1);
    byte_mode = 1; big_end = 0;
    @(negedge clk);
    tx_entry(mk(40), 0, "R8 tx cfg frozen");
    rx_entry(mk(41), "R8 rx cfg frozen");
    do_reset(1, 0);
    byte_mode = 0; big_end = 1;
    tx_entry(mk(42), 1, "R8 tx cfg frozen");
    rx_entry(mk(43), "R8 rx cfg frozen");

    // R9: transmit FIFO fills, then drains in order
    do_reset(0, 1);
    for (int i = 0; i < 4; i++) send_wide(mk(50 + i));
    chk(!tx_wready, "R9 tx full", 36'(tx_wready), 36'd0);
    for (int i = 0; i < 4; i++) begin
      for (int k = 0; k < 2; k++) begin
        recv_narrow(exp_piece(mk(50 + i), 0, 1, k), 0, "R9 tx order");
        if (i == 0 && k == 0)
          chk(!tx_wready, "R9 entry kept until last piece", 36'(tx_wready), 36'd0);
      end
    end
    chk(tx_wready && !tx_nvalid, "R9 tx drained", {tx_wready, tx_nvalid}, 2'b10);

    // R9: receive FIFO fills and back-pressures the final piece
    do_reset(1, 1);
    for (int i = 0; i < 4; i++)
      for (int k = 0; k < 4; k++) send_narrow(rx_piece(mk(60 + i), k));
    for (int k = 0; k < 3; k++) send_narrow(rx_piece(mk(64), k));
    rx_ndata = rx_piece(mk(64), 3); rx_nvalid = 1;
    chk(!rx_nready, "R9 rx full stalls last piece", 36'(rx_nready), 36'd0);
    @(negedge clk);
    chk(!rx_nready, "R7 rx stall held", 36'(rx_nready), 36'd0);
    read_wide(mk(60), "R9 rx order");
    @(negedge clk);
    rx_nvalid = 0;
    for (int i = 1; i < 5; i++) read_wide(mk(60 + i), "R9 rx order");
    chk(!rx_wvalid, "R7 no duplicate entry", 36'(rx_wvalid), 36'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule